// File: doc/BRIEF.md
# Table Jump Execution Unit

This unit carries out the two compressed table-jump instructions of a small embedded core. A 16-bit instruction word arrives with its PC. The unit recognises the table-jump encoding and takes an 8-bit slot number from it. It forms the address of a table entry from a base held in its own control register, and reads that one entry from memory. It then redirects the fetch stream to the entry value with bit 0 cleared. Slots 32 and above also write the return address to x1. Slots below 32 do not.

The control register holds a table base and a 6-bit mode. Software reaches it through a simple CSR port at address 0x017. Table jumps are legal only while the mode is zero. A core with a state-enable mechanism can also close access to the register through an enable input. While access is closed, both register access and table jumps are flagged illegal.

The table-jump encodings share space with the compressed double-precision stack store. For a core that keeps that store, a build parameter makes the unit ignore every word.

Top module: `tablejump_unit`

## Requirements
- R1: A word is taken as a table jump only when `ins_valid` is high, bits [1:0] are 2'b10 and bits [15:10] are 6'b101000. Any other word causes no memory request, no redirect and no illegal flag.
- R2: Slot numbers 0 to 31, taken from bits [9:2], redirect without a link write (`link_we` stays low).
- R3: Slot numbers 32 to 255 redirect and, in the same cycle, raise `link_we` with `link_rd` = 1 and `link_data` = PC + 2.
- R4: The memory read address is base + slot × 4, where base is the control register value with bits [5:0] cleared.
- R5: One cycle after the clock edge that samples `mem_rvalid`, `redir_valid` pulses for one cycle. At the same time `redir_pc` carries `mem_rdata` with bit 0 forced to 0.
- R6: A table jump that arrives while mode (bits [5:0] of the control register) is nonzero raises `illegal` for one cycle on the next cycle. It makes no memory request and no redirect.
- R7: The control register sits at CSR address 0x017 and resets to 0. Bits [5:0] (mode) and bits [25:6] (base) are writable. Bits [31:26] always read as 0.
- R8: While `stateen_jvt` is low, a CSR access to 0x017 raises `csr_illegal` and any write is dropped. A table jump in that state raises `illegal` as in R6.
- R9: Each accepted table jump issues exactly one single-cycle `mem_req`, on the cycle after it is accepted. Instruction words that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word is present |
| ins_word | input | 16 | Compressed instruction word |
| ins_pc | input | 32 | PC of the instruction |
| stateen_jvt | input | 1 | State-enable bit granting access to the table register |
| csr_valid | input | 1 | CSR access strobe |
| csr_write | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| csr_illegal | output | 1 | CSR access refused by the state gate |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 32 | Table entry address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| busy | output | 1 | A table jump is in flight |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | 32 | Redirect target |
| link_we | output | 1 | Return-address write enable |
| link_rd | output | 5 | Return-address register number |
| link_data | output | 32 | Return address |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The assertions assume that memory answers only a request it has been given. They also assume at most one response per request, and a response no earlier than the cycle in which `mem_req` is high. Any other `mem_rvalid` would look like a spurious redirect. The stimulus keeps to this by driving exactly one response per observed request, after a latency of 0 to 2 cycles. CSR accesses and instruction words change only on the falling edge. An intruding instruction is offered only while a jump is already in flight.

// File: rtl/tj_pkg.sv
package tj_pkg;
  localparam logic [5:0] TJ_FUNCT6   = 6'b101000;
  localparam logic [1:0] TJ_OP       = 2'b10;
  localparam int         LINK_FIRST  = 32;
  localparam int         MODE_W      = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} tj_state_e;

  function automatic logic tj_match(input logic [15:0] w);
    return (w[1:0] == TJ_OP) && (w[15:10] == TJ_FUNCT6);
  endfunction

  function automatic logic [7:0] tj_slot(input logic [15:0] w);
    return w[9:2];
  endfunction

  function automatic logic tj_links(input logic [7:0] slot);
    return slot >= 8'(LINK_FIRST);
  endfunction
endpackage

// File: rtl/tj_decode.sv
module tj_decode #(
  parameter bit DP_STORE_PRESENT = 1'b0
) (
  input  logic        valid,
  input  logic [15:0] word,
  output logic        hit,
  output logic [7:0]  slot,
  output logic        links
);
  import tj_pkg::*;

  assign slot  = tj_slot(word);
  assign links = tj_links(slot);

  generate
    if (DP_STORE_PRESENT) begin : g_inert
      assign hit = 1'b0;
    end else begin : g_active
      assign hit = valid && tj_match(word);
    end
  endgenerate
endmodule

// File: rtl/tj_csr.sv
module tj_csr #(
  parameter int          XLEN         = 32,
  parameter int          BASE_IMPL    = 20,
  parameter logic [11:0] CSR_ADDR     = 12'h017,
  parameter bit          HAS_STATE_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_valid,
  input  logic            csr_write,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            stateen_jvt,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic [XLEN-1:0] base,
  output logic            mode_zero,
  output logic            gate_open
);
  localparam int MODE_W = tj_pkg::MODE_W;
  localparam logic [XLEN-1:0] MODE_MASK = XLEN'((1 << MODE_W) - 1);
  localparam logic [XLEN-1:0] BASE_MASK =
    ({XLEN{1'b1}} >> (XLEN - MODE_W - BASE_IMPL)) & ~MODE_MASK;
  localparam logic [XLEN-1:0] WR_MASK = BASE_MASK | MODE_MASK;

  logic [XLEN-1:0] reg_q;
  logic            sel;
  logic            wr_ok;

  generate
    if (HAS_STATE_EN) begin : g_gate
      assign gate_open = stateen_jvt;
    end else begin : g_nogate
      assign gate_open = 1'b1;
    end
  endgenerate

  assign sel         = csr_valid && (csr_addr == CSR_ADDR);
  assign csr_illegal = sel && !gate_open;
  assign csr_rdata   = (sel && gate_open) ? reg_q : '0;
  assign wr_ok       = sel && gate_open && csr_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_q <= '0;
    else if (wr_ok) reg_q <= csr_wdata & WR_MASK;
  end

  assign base      = reg_q & BASE_MASK;
  assign mode_zero = (reg_q[MODE_W-1:0] == '0);
endmodule

// File: rtl/tj_seq.sv
module tj_seq #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [7:0]      slot,
  input  logic            links,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic            mode_zero,
  input  logic            gate_open,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  output logic            busy,
  output logic            start,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            illegal
);
  import tj_pkg::*;

  localparam int SHIFT = $clog2(XLEN / 8);

  function automatic logic [XLEN-1:0] entry_addr(input logic [XLEN-1:0] b,
                                                 input logic [7:0] s);
    return b + (XLEN'(s) << SHIFT);
  endfunction

  tj_state_e       state_q;
  logic [XLEN-1:0] addr_q, pc_q;
  logic            links_q;
  logic            accept, reject, resp;

  assign accept = hit && (state_q == ST_IDLE);
  assign reject = accept && !(mode_zero && gate_open);
  assign start  = accept && !reject;
  assign resp   = mem_rvalid && (state_q != ST_IDLE);

  assign mem_req  = (state_q == ST_REQ);
  assign mem_addr = addr_q;
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      pc_q        <= '0;
      links_q     <= 1'b0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      link_we     <= 1'b0;
      link_data   <= '0;
      illegal     <= 1'b0;
    end else begin
      illegal     <= reject;
      redir_valid <= 1'b0;
      link_we     <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          addr_q  <= entry_addr(base, slot);
          pc_q    <= pc;
          links_q <= links;
          state_q <= ST_REQ;
        end
        default: if (resp) begin
          redir_valid <= 1'b1;
          redir_pc    <= {mem_rdata[XLEN-1:1], 1'b0};
          link_we     <= links_q;
          link_data   <= pc_q + XLEN'(2);
          state_q     <= ST_IDLE;
        end else begin
          state_q <= ST_WAIT;
        end
      endcase
    end
  end
endmodule

// File: rtl/tablejump_unit.sv
module tablejump_unit #(
  parameter int          XLEN             = 32,
  parameter int          BASE_IMPL        = 20,
  parameter logic [11:0] CSR_ADDR         = 12'h017,
  parameter bit          HAS_STATE_EN     = 1'b1,
  parameter bit          DP_STORE_PRESENT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic [15:0]     ins_word,
  input  logic [XLEN-1:0] ins_pc,
  input  logic            stateen_jvt,
  input  logic            csr_valid,
  input  logic            csr_write,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            link_we,
  output logic [4:0]      link_rd,
  output logic [XLEN-1:0] link_data,
  output logic            illegal
);
  localparam logic [4:0] RA = 5'd1;

  logic            tj_hit, tj_links, tj_start;
  logic [7:0]      tj_slot;
  logic [XLEN-1:0] tbl_base;
  logic            mode_zero, gate_open;

  tj_decode #(.DP_STORE_PRESENT(DP_STORE_PRESENT)) u_dec (
    .valid(ins_valid), .word(ins_word),
    .hit(tj_hit), .slot(tj_slot), .links(tj_links)
  );

  tj_csr #(.XLEN(XLEN), .BASE_IMPL(BASE_IMPL), .CSR_ADDR(CSR_ADDR),
           .HAS_STATE_EN(HAS_STATE_EN)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_write(csr_write),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .stateen_jvt(stateen_jvt),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .base(tbl_base),
    .mode_zero(mode_zero), .gate_open(gate_open)
  );

  tj_seq #(.XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .hit(tj_hit), .slot(tj_slot), .links(tj_links),
    .pc(ins_pc), .base(tbl_base), .mode_zero(mode_zero), .gate_open(gate_open),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .busy(busy), .start(tj_start),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .link_we(link_we),
    .link_data(link_data), .illegal(illegal)
  );

  assign link_rd = RA;
endmodule

// File: rtl/tablejump_unit_chk.sv
module tablejump_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic ins_valid,
  input logic tj_start,
  input logic mem_req,
  input logic mem_rvalid,
  input logic redir_valid,
  input logic redir_pc0,
  input logic link_we,
  input logic illegal,
  input logic busy
);
  a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(tj_start));
  a_r6_illegal_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(ins_valid));
  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!redir_valid && !mem_req));
  a_r5_redirect_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(mem_rvalid));
  a_r5_target_even: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !redir_pc0);
  a_r5_idle_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !busy);
  a_r3_link_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> redir_valid);
endmodule

bind tablejump_unit tablejump_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .tj_start(tj_start),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .redir_valid(redir_valid),
  .redir_pc0(redir_pc[0]), .link_we(link_we), .illegal(illegal), .busy(busy)
);

// File: tb/tablejump_unit_test.sv
`timescale 1ns/1ps
module tablejump_unit_test;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [15:0] ins_word = '0;
  logic [XLEN-1:0] ins_pc = '0;
  logic stateen_jvt = 1'b1;
  logic csr_valid = 1'b0, csr_write = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic csr_illegal, mem_req, busy, redir_valid, link_we, illegal;
  logic [XLEN-1:0] mem_addr, redir_pc, link_data;
  logic mem_rvalid = 1'b0;
  logic [XLEN-1:0] mem_rdata = '0;
  logic [4:0] link_rd;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tablejump_unit uut (.*);

  function automatic logic [15:0] tj_word(input logic [7:0] s);
    return {6'b101000, s, 2'b10};
  endfunction
  function automatic logic [31:0] exp_addr(input logic [31:0] reg_v, input int s);
    return {reg_v[31:6], 6'b0} + 32'(s * 4);
  endfunction
  function automatic logic [31:0] table_val(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5A5A_0001;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic csr_wr(input logic [31:0] d);
    @(negedge clk);
    csr_valid = 1; csr_write = 1; csr_addr = 12'h017; csr_wdata = d;
    @(negedge clk);
    csr_valid = 0; csr_write = 0;
  endtask

  task automatic csr_rd(output logic [31:0] d, output logic ill);
    @(negedge clk);
    csr_valid = 1; csr_write = 0; csr_addr = 12'h017;
    #1;
    d = csr_rdata; ill = csr_illegal;
    csr_valid = 0;
  endtask

  // Legal table jump: request, response after lat cycles, redirect check.
  task automatic do_tj(input logic [31:0] reg_v, input int s,
                       input logic [31:0] pc, input int lat, input bit intrude);
    logic [31:0] a, t;
    a = exp_addr(reg_v, s);
    t = table_val(a);
    @(negedge clk);
    ins_valid = 1; ins_word = tj_word(8'(s)); ins_pc = pc;
    @(negedge clk);
    if (intrude) begin
      ins_word = tj_word(8'(255 - s)); ins_pc = pc + 32'h40;
    end else ins_valid = 0;
    check(mem_req === 1'b1, "R9 request issued", 32'(mem_req), 32'd1);
    check(mem_addr === a, "R4 entry address", mem_addr, a);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      ins_valid = 0;
      check(mem_req === 1'b0, "R9 request single cycle", 32'(mem_req), 32'd0);
    end
    mem_rvalid = 1; mem_rdata = t;
    @(negedge clk);
    mem_rvalid = 0; ins_valid = 0;
    check(redir_valid === 1'b1, "R5 redirect pulse", 32'(redir_valid), 32'd1);
    check(redir_pc === {t[31:1], 1'b0}, "R5 target bit0 cleared", redir_pc,
          {t[31:1], 1'b0});
    if (s >= 32) begin
      check(link_we === 1'b1 && link_rd === 5'd1, "R3 link to x1",
            {link_we, 26'd0, link_rd}, {1'b1, 26'd0, 5'd1});
      check(link_data === pc + 32'd2, "R3 return address", link_data, pc + 32'd2);
    end else begin
      check(link_we === 1'b0, "R2 no link for low slots", 32'(link_we), 32'd0);
    end
    @(negedge clk);
    check(redir_valid === 1'b0 && mem_req === 1'b0 && busy === 1'b0,
          "R9 no second request", {redir_valid, mem_req, busy}, 32'd0);
  endtask

  task automatic expect_illegal(input int s, input string req);
    @(negedge clk);
    ins_valid = 1; ins_word = tj_word(8'(s)); ins_pc = 32'h100;
    @(negedge clk);
    ins_valid = 0;
    check(illegal === 1'b1 && mem_req === 1'b0, req, {illegal, mem_req},
          32'b10);
    @(negedge clk);
    check(illegal === 1'b0 && redir_valid === 1'b0 && busy === 1'b0, req,
          {illegal, redir_valid, busy}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] rv, base_v;
    logic ill;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({redir_valid, mem_req, illegal, busy, link_we} === 5'd0,
          "R5 reset outputs quiet", {redir_valid, mem_req, illegal, busy}, 0);
    csr_rd(rv, ill);
    check(rv === 32'd0, "R7 reset value", rv, 32'd0);

    // R7: field widths and WARL base
    csr_wr(32'hFFFF_FFFF);
    csr_rd(rv, ill);
    check(rv === 32'h03FF_FFFF, "R7 WARL mask", rv, 32'h03FF_FFFF);
    csr_wr(32'h0001_2345);
    csr_rd(rv, ill);
    check(rv === 32'h0001_2345, "R7 base and mode readback", rv, 32'h0001_2345);

    // R6: nonzero mode makes table jumps illegal
    expect_illegal(3, "R6 mode nonzero illegal");
    expect_illegal(200, "R6 mode nonzero illegal");

    base_v = 32'h0001_2340;
    csr_wr(base_v);
    // Boundary slots
    do_tj(base_v, 0,   32'h0000_1000, 0, 0);
    do_tj(base_v, 31,  32'h0000_1002, 1, 0);
    do_tj(base_v, 32,  32'h0000_1004, 2, 0);
    do_tj(base_v, 255, 32'hFFFF_FFFE, 1, 0);

    // R9: words arriving while busy are ignored
    do_tj(base_v, 40, 32'h0000_2000, 2, 1);

    // R1: non-matching words do nothing
    @(negedge clk);
    ins_valid = 1; ins_word = 16'b101110_00000000_10; ins_pc = 32'h300;
    @(negedge clk);
    ins_word = {6'b101000, 8'd5, 2'b01};
    @(negedge clk);
    ins_valid = 0;
    check(mem_req === 1'b0 && illegal === 1'b0 && busy === 1'b0,
          "R1 foreign word ignored", {mem_req, illegal, busy}, 32'd0);
    @(negedge clk);
    check(mem_req === 1'b0 && illegal === 1'b0 && redir_valid === 1'b0,
          "R1 foreign word ignored", {mem_req, illegal, redir_valid}, 32'd0);

    // R8: state gate closed
    stateen_jvt = 0;
    csr_rd(rv, ill);
    check(ill === 1'b1, "R8 gated access flagged", 32'(ill), 32'd1);
    csr_wr(32'h0000_0FC0);
    expect_illegal(50, "R8 gated jump illegal");
    stateen_jvt = 1;
    csr_rd(rv, ill);
    check(rv === base_v && ill === 1'b0, "R8 gated write dropped", rv, base_v);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int s, lat;
      logic [31:0] pc;
      if (i % 10 == 0) begin
        base_v = $urandom() & 32'h03FF_FFC0;
        csr_wr(base_v);
      end
      s = int'($urandom_range(255, 0));
      lat = int'($urandom_range(2, 0));
      pc = $urandom() & 32'hFFFF_FFFE;
      do_tj(base_v, s, pc, lat, 0);
    end

    finish_run();
  end
endmodule